// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

This block sits at the issue point of an out-of-order core. Instructions arrive here once they are ready. Each one is filed into a small ready queue for its operation class, and each class queue feeds one type of functional unit. Every cycle the selector sends out up to `ISSUE_W` instructions on parallel issue lanes. It picks them oldest first across all classes, and age comes from a 16-bit sequence number that is compared as an unsigned value.

The selector keeps an age-order list: one registered record per class giving whether the class queue is on the list and the sequence number of its oldest entry. Selection walks these records from oldest to youngest. A class whose functional unit is busy is skipped for the cycle, and the next-oldest class takes its lane. After an issue or an insert, each record is moved so that it reflects the new oldest entry of its queue.

A flush drops every entry younger than the squash sequence number in a single cycle. In the cycle after that, the list is rebuilt from the queue heads that survived. Nothing issues and no insert is accepted during either of those two cycles.

Top module: `iss_age_sel`

## Requirements
- R1: After reset, no issue lane is valid and `ins_stall` is low while `ins_valid` is low.
- R2: Across classes, lane 0 carries the eligible class head with the smallest sequence number. Each further valid lane carries the next-smallest eligible head, so sequence numbers increase with the lane index.
- R3: No more than `ISSUE_W` lanes are valid in a cycle, and a class appears on at most one lane per cycle. Valid lanes are packed from lane 0 upward.
- R4: Within one class, entries issue in increasing sequence-number order, whatever order they were inserted in.
- R5: A class whose bit in `fu_avail` is 0 issues nothing in that cycle and keeps all its entries. Its lane goes to the next-oldest eligible class.
- R6: An insert into a class queue that already holds `DEPTH` entries raises `ins_stall` in that cycle and is not stored.
- R7: A flush removes every entry whose sequence number is strictly greater than `flush_seq`. Entries with a sequence number at or below `flush_seq` stay queued.
- R8: In the flush cycle and in the rebuild cycle after it, no lane is valid, `ins_stall` is high for any insert, and such an insert is not stored.
- R9: Sequence numbers are compared as 16-bit unsigned values (0x0001 is older than 0x8000).
- R10: `ins_class` is a binary class index from 0 to `NUM_CLASSES-1`. An issued instruction reports that same index on its lane's `iss_class` field, together with the tag it was inserted with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Ready instruction offered for insertion |
| ins_seq | input | 16 | Sequence number of the offered instruction |
| ins_class | input | CLS_W | Operation class index of the offered instruction |
| ins_tag | input | TAG_W | Tag carried through to issue |
| ins_stall | output | 1 | Offered instruction is not accepted this cycle |
| fu_avail | input | NUM_CLASSES | Per-class functional-unit availability |
| flush_valid | input | 1 | Squash request |
| flush_seq | input | 16 | Entries younger than this number are removed |
| iss_valid | output | ISSUE_W | Per-lane issue valid |
| iss_tag | output | ISSUE_W*TAG_W | Per-lane tag, lane k at bits k*TAG_W upward |
| iss_class | output | ISSUE_W*CLS_W | Per-lane class index, lane k at bits k*CLS_W upward |

## Verification
The assertions check on every cycle that:
- lanes are packed and strictly increasing in age;
- no class is granted twice and no busy class is granted;
- no write lands on a full queue;
- nothing issues in the flush or rebuild cycle;
- each age-order record agrees with the head that its class queue computes independently.

Only the bench scenarios can show which entries actually come out and in what order. That covers insertion out of order within a class, survival of entries across a busy cycle, the fate of an insert refused by a full queue, the exact boundary of a flush, and the unsigned wrap of the age compare. The bench follows these with a reference model that ranks eligible heads.

// File: rtl/iss_sel_pkg.sv
package iss_sel_pkg;
  localparam int SEQ_W = 16;
  typedef logic [SEQ_W-1:0] seq_t;

  // True when a is strictly older than b (unsigned, smaller number is older)
  function automatic logic seq_older(input seq_t a, input seq_t b);
    return a < b;
  endfunction

  // True when an entry with sequence s is squashed by a flush at f
  function automatic logic seq_squashed(input seq_t s, input seq_t f);
    return s > f;
  endfunction
endpackage

// File: rtl/iss_class_q.sv
module iss_class_q
  import iss_sel_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  seq_t             wr_seq,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             pop,
  input  logic             flush_valid,
  input  seq_t             flush_seq,
  output logic             full,
  output logic             nonempty,
  output seq_t             head_seq,
  output logic [TAG_W-1:0] head_tag,
  output logic             has_next,
  output seq_t             next_seq
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]            ent_v;
  seq_t [DEPTH-1:0]            ent_seq;
  logic [DEPTH-1:0][TAG_W-1:0] ent_tag;

  logic [IDX_W-1:0] head_idx, next_idx, free_idx;
  logic             free_ok;

  // Oldest valid entry, second-oldest valid entry and first free slot
  always_comb begin
    nonempty = 1'b0;
    head_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_v[i] && (!nonempty || seq_older(ent_seq[i], ent_seq[head_idx]))) begin
        nonempty = 1'b1;
        head_idx = IDX_W'(i);
      end
    end
    has_next = 1'b0;
    next_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_v[i] && (IDX_W'(i) != head_idx) &&
          (!has_next || seq_older(ent_seq[i], ent_seq[next_idx]))) begin
        has_next = 1'b1;
        next_idx = IDX_W'(i);
      end
    end
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_v[i]) begin
        free_ok  = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign full     = !free_ok;
  assign head_seq = ent_seq[head_idx];
  assign head_tag = ent_tag[head_idx];
  assign next_seq = ent_seq[next_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v   <= '0;
      ent_seq <= '0;
      ent_tag <= '0;
    end else if (flush_valid) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_v[i] && seq_squashed(ent_seq[i], flush_seq)) ent_v[i] <= 1'b0;
      end
    end else begin
      if (pop) ent_v[head_idx] <= 1'b0;
      if (wr_en && free_ok) begin
        ent_v[free_idx]   <= 1'b1;
        ent_seq[free_idx] <= wr_seq;
        ent_tag[free_idx] <= wr_tag;
      end
    end
  end

  // R6: the parent never offers a write to a full queue
  a_r6_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  // R4: a pop only happens when the queue holds a head
  a_r4_pop_has_head: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);
endmodule

// File: rtl/iss_age_pick.sv
module iss_age_pick
  import iss_sel_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int ISSUE_W     = 2,
  parameter int CLS_W       = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CLASSES-1:0]          list_on,
  input  seq_t [NUM_CLASSES-1:0]          list_seq,
  input  logic [NUM_CLASSES-1:0]          fu_avail,
  input  logic                            block,
  output logic [ISSUE_W-1:0]              lane_valid,
  output logic [ISSUE_W-1:0][CLS_W-1:0]   lane_cls,
  output seq_t [ISSUE_W-1:0]              lane_seq,
  output logic [NUM_CLASSES-1:0]          grant
);
  logic [NUM_CLASSES-1:0] elig;
  logic                   found;
  logic [CLS_W-1:0]       best;

  assign elig = block ? '0 : (list_on & fu_avail);

  // Walk the age-order records: each lane takes the oldest class not yet taken
  always_comb begin
    grant      = '0;
    lane_valid = '0;
    lane_cls   = '0;
    lane_seq   = '0;
    found      = 1'b0;
    best       = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      found = 1'b0;
      best  = '0;
      for (int c = 0; c < NUM_CLASSES; c++) begin
        if (elig[c] && !grant[c] &&
            (!found || seq_older(list_seq[c], list_seq[best]))) begin
          found = 1'b1;
          best  = CLS_W'(c);
        end
      end
      if (found) begin
        lane_valid[k] = 1'b1;
        lane_cls[k]   = best;
        lane_seq[k]   = list_seq[best];
        grant[best]   = 1'b1;
      end
    end
  end

  // R3: one lane per granted class, no class twice
  a_r3_class_once: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == $countones(lane_valid));

  generate
    for (genvar k = 1; k < ISSUE_W; k++) begin : g_lane_chk
      // R3: lanes fill from lane 0 upward
      a_r3_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid[k] |-> lane_valid[k-1]);
      // R2: later lanes carry younger instructions
      a_r2_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid[k] |-> seq_older(lane_seq[k-1], lane_seq[k]));
    end
    for (genvar k = 0; k < ISSUE_W; k++) begin : g_avail_chk
      // R5: a busy class is never granted
      a_r5_busy_skip: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid[k] |-> fu_avail[lane_cls[k]]);
    end
  endgenerate
endmodule

// File: rtl/iss_age_sel.sv
module iss_age_sel
  import iss_sel_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int DEPTH       = 4,
  parameter int ISSUE_W     = 2,
  parameter int TAG_W       = 8,
  parameter int CLS_W       = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ins_valid,
  input  logic [15:0]                ins_seq,
  input  logic [CLS_W-1:0]           ins_class,
  input  logic [TAG_W-1:0]           ins_tag,
  output logic                       ins_stall,
  input  logic [NUM_CLASSES-1:0]     fu_avail,
  input  logic                       flush_valid,
  input  logic [15:0]                flush_seq,
  output logic [ISSUE_W-1:0]         iss_valid,
  output logic [ISSUE_W*TAG_W-1:0]   iss_tag,
  output logic [ISSUE_W*CLS_W-1:0]   iss_class
);
  // Age-order records, one per class
  logic [NUM_CLASSES-1:0] list_on;
  seq_t [NUM_CLASSES-1:0] list_seq;
  logic                   rebuild_q;

  // Queue-side views
  logic [NUM_CLASSES-1:0]            q_full, q_nonempty, q_has_next;
  seq_t [NUM_CLASSES-1:0]            q_head_seq, q_next_seq;
  logic [NUM_CLASSES-1:0][TAG_W-1:0] q_head_tag;

  // Internal events brought out for checking
  logic                              block_issue;
  logic                              ins_accept;
  logic [NUM_CLASSES-1:0]            wr_en;
  logic [NUM_CLASSES-1:0]            grant;
  logic [ISSUE_W-1:0]                lane_valid;
  logic [ISSUE_W-1:0][CLS_W-1:0]     lane_cls;
  seq_t [ISSUE_W-1:0]                lane_seq;

  assign block_issue = flush_valid || rebuild_q;
  assign ins_stall   = ins_valid &&
                       (block_issue || (int'(ins_class) >= NUM_CLASSES) || q_full[ins_class]);
  assign ins_accept  = ins_valid && !ins_stall;

  generate
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
      assign wr_en[c] = ins_accept && (ins_class == CLS_W'(c));

      iss_class_q #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_q (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en[c]),
        .wr_seq      (ins_seq),
        .wr_tag      (ins_tag),
        .pop         (grant[c]),
        .flush_valid (flush_valid),
        .flush_seq   (flush_seq),
        .full        (q_full[c]),
        .nonempty    (q_nonempty[c]),
        .head_seq    (q_head_seq[c]),
        .head_tag    (q_head_tag[c]),
        .has_next    (q_has_next[c]),
        .next_seq    (q_next_seq[c])
      );

      // Record maintenance: add on insert into empty, move on issue or older insert
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          list_on[c]  <= 1'b0;
          list_seq[c] <= '0;
        end else if (flush_valid) begin
          list_on[c]  <= 1'b0;
        end else if (rebuild_q) begin
          list_on[c]  <= q_nonempty[c];
          list_seq[c] <= q_head_seq[c];
        end else if (grant[c] && wr_en[c]) begin
          list_on[c]  <= 1'b1;
          list_seq[c] <= (q_has_next[c] && seq_older(q_next_seq[c], ins_seq))
                         ? q_next_seq[c] : ins_seq;
        end else if (grant[c]) begin
          list_on[c]  <= q_has_next[c];
          list_seq[c] <= q_next_seq[c];
        end else if (wr_en[c]) begin
          list_on[c]  <= 1'b1;
          list_seq[c] <= (list_on[c] && seq_older(list_seq[c], ins_seq))
                         ? list_seq[c] : ins_seq;
        end
      end

      // R2: outside the rebuild cycle each record mirrors its queue's head
      a_r2_list_tracks_head: assert property (@(posedge clk) disable iff (!rst_n)
        !rebuild_q |-> ((list_on[c] == q_nonempty[c]) &&
                        (!q_nonempty[c] || (list_seq[c] == q_head_seq[c]))));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) rebuild_q <= 1'b0;
    else        rebuild_q <= flush_valid;
  end

  iss_age_pick #(.NUM_CLASSES(NUM_CLASSES), .ISSUE_W(ISSUE_W), .CLS_W(CLS_W)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .list_on    (list_on),
    .list_seq   (list_seq),
    .fu_avail   (fu_avail),
    .block      (block_issue),
    .lane_valid (lane_valid),
    .lane_cls   (lane_cls),
    .lane_seq   (lane_seq),
    .grant      (grant)
  );

  always_comb begin
    for (int k = 0; k < ISSUE_W; k++) begin
      iss_valid[k]                 = lane_valid[k];
      iss_tag[k*TAG_W +: TAG_W]    = q_head_tag[lane_cls[k]];
      iss_class[k*CLS_W +: CLS_W]  = lane_cls[k];
    end
  end

  // R8: quiet in the flush cycle and in the rebuild cycle
  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (iss_valid == '0));
  a_r8_rebuild_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (iss_valid == '0));
  // R6: an accepted insert never targets a full queue
  a_r6_full_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && q_full[ins_class]) |-> (wr_en == '0));
endmodule

// File: tb/iss_age_sel_test.sv
module iss_age_sel_test;
  localparam int NC  = 4;
  localparam int DEP = 4;
  localparam int W   = 2;
  localparam int TW  = 8;
  localparam int CW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 1'b0;
  logic [15:0]   ins_seq = '0;
  logic [CW-1:0] ins_class = '0;
  logic [TW-1:0] ins_tag = '0;
  logic          ins_stall;
  logic [NC-1:0] fu_avail = '0;
  logic          flush_valid = 1'b0;
  logic [15:0]   flush_seq = '0;
  logic [W-1:0]  iss_valid;
  logic [W*TW-1:0] iss_tag;
  logic [W*CW-1:0] iss_class;

  int checks = 0;
  int failures = 0;

  // Reference model
  bit mv [NC][DEP];
  int ms [NC][DEP];
  int mt [NC][DEP];

  always #4 clk = ~clk;

  iss_age_sel #(.NUM_CLASSES(NC), .DEPTH(DEP), .ISSUE_W(W), .TAG_W(TW), .CLS_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_seq(ins_seq),
    .ins_class(ins_class), .ins_tag(ins_tag), .ins_stall(ins_stall),
    .fu_avail(fu_avail), .flush_valid(flush_valid), .flush_seq(flush_seq),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_class(iss_class)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_count(input int c);
    int n = 0;
    for (int d = 0; d < DEP; d++) if (mv[c][d]) n++;
    return n;
  endfunction

  // Returns slot of the smallest sequence in class c, or -1 when empty
  function automatic int m_head(input int c);
    int h = -1;
    for (int d = 0; d < DEP; d++)
      if (mv[c][d] && (h < 0 || ms[c][d] < ms[c][h])) h = d;
    return h;
  endfunction

  task automatic m_clear();
    for (int c = 0; c < NC; c++)
      for (int d = 0; d < DEP; d++) mv[c][d] = 1'b0;
  endtask

  task automatic do_insert(input int c, input int seq, input int tag);
    bit exp_stall;
    @(negedge clk);
    ins_valid = 1'b1; ins_class = CW'(c); ins_seq = 16'(seq); ins_tag = TW'(tag);
    #1;
    exp_stall = (m_count(c) == DEP);
    chk(ins_stall == exp_stall, "R6 stall on insert", int'(ins_stall), int'(exp_stall));
    @(posedge clk);
    if (!exp_stall) begin
      for (int d = 0; d < DEP; d++) begin
        if (!mv[c][d]) begin
          mv[c][d] = 1'b1; ms[c][d] = seq; mt[c][d] = tag;
          break;
        end
      end
    end
    #1 ins_valid = 1'b0;
  endtask

  // Issue cycles against the model: the rank of each eligible head picks its lane
  task automatic drain(input logic [NC-1:0] avail, input int max_cycles, input string req);
    for (int cyc = 0; cyc < max_cycles; cyc++) begin
      int lane_of [NC];
      int hd [NC];
      int n_exp;
      @(negedge clk);
      fu_avail = avail;
      #1;
      n_exp = 0;
      for (int c = 0; c < NC; c++) begin
        hd[c] = m_head(c);
        lane_of[c] = -1;
      end
      for (int c = 0; c < NC; c++) begin
        if (hd[c] >= 0 && avail[c]) begin
          int rank = 0;
          for (int o = 0; o < NC; o++)
            if (o != c && hd[o] >= 0 && avail[o] && ms[o][hd[o]] < ms[c][hd[c]]) rank++;
          if (rank < W) begin lane_of[c] = rank; n_exp++; end
        end
      end
      chk($countones(iss_valid) == n_exp, {req, " R3 lane count"}, $countones(iss_valid), n_exp);
      for (int c = 0; c < NC; c++) begin
        if (lane_of[c] >= 0) begin
          int l = lane_of[c];
          chk(iss_valid[l] == 1'b1, {req, " R2 lane valid"}, int'(iss_valid[l]), 1);
          chk(int'(iss_class[l*CW +: CW]) == c, {req, " R10 lane class"},
              int'(iss_class[l*CW +: CW]), c);
          chk(int'(iss_tag[l*TW +: TW]) == mt[c][hd[c]], {req, " R4 lane tag"},
              int'(iss_tag[l*TW +: TW]), mt[c][hd[c]]);
        end
      end
      @(posedge clk);
      for (int c = 0; c < NC; c++) if (lane_of[c] >= 0) mv[c][hd[c]] = 1'b0;
      #1 fu_avail = '0;
      if (n_exp == 0) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    fu_avail = '1;
    #1;
    chk(iss_valid == '0, "R1 no issue after reset", int'(iss_valid), 0);
    chk(ins_stall == 1'b0, "R1 stall low after reset", int'(ins_stall), 0);
    fu_avail = '0;
  endtask

  task automatic t_cross_class();
    do_insert(0, 30, 8'h30);
    do_insert(1, 10, 8'h10);
    do_insert(2, 20, 8'h20);
    do_insert(3, 40, 8'h40);
    drain('1, 6, "R2 cross-class");
  endtask

  task automatic t_in_class();
    do_insert(2, 50, 8'h50);
    do_insert(2, 45, 8'h45);
    do_insert(2, 60, 8'h60);
    do_insert(1, 55, 8'h55);
    drain('1, 6, "R4 in-class");
  endtask

  task automatic t_busy();
    do_insert(0, 5, 8'h05);
    do_insert(1, 6, 8'h06);
    do_insert(3, 7, 8'h07);
    drain(4'b1110, 1, "R5 busy class0");
    // class 0 entry must still be there
    @(negedge clk);
    fu_avail = '1;
    #1;
    chk(iss_valid[0] && iss_class[CW-1:0] == 2'd0, "R5 busy entry kept",
        int'(iss_class[CW-1:0]), 0);
    fu_avail = '0;
    drain('1, 3, "R5 resume");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEP + 1; i++) do_insert(1, 70 + i, 8'h70 + i);
    drain('1, DEP + 2, "R6 after full");
  endtask

  task automatic t_flush();
    do_insert(0, 100, 8'hA0);
    do_insert(0, 200, 8'hA1);
    do_insert(1, 150, 8'hA2);
    do_insert(2, 300, 8'hA3);
    @(negedge clk);
    flush_valid = 1'b1; flush_seq = 16'd150;
    ins_valid = 1'b1; ins_class = 2'd3; ins_seq = 16'd120; ins_tag = 8'hB0;
    fu_avail = '1;
    #1;
    chk(iss_valid == '0, "R8 no issue in flush cycle", int'(iss_valid), 0);
    chk(ins_stall == 1'b1, "R8 stall in flush cycle", int'(ins_stall), 1);
    @(posedge clk);
    #1 flush_valid = 1'b0;
    for (int c = 0; c < NC; c++)
      for (int d = 0; d < DEP; d++)
        if (mv[c][d] && ms[c][d] > 150) mv[c][d] = 1'b0;
    ins_seq = 16'd121;
    #1;
    chk(iss_valid == '0, "R8 no issue in rebuild cycle", int'(iss_valid), 0);
    chk(ins_stall == 1'b1, "R8 stall in rebuild cycle", int'(ins_stall), 1);
    @(posedge clk);
    #1 ins_valid = 1'b0; fu_avail = '0;
    drain('1, 5, "R7 flush survivors");
  endtask

  task automatic t_unsigned();
    do_insert(0, 16'h8000, 8'hC0);
    do_insert(1, 16'h0001, 8'hC1);
    do_insert(2, 16'hFFFF, 8'hC2);
    @(negedge clk);
    fu_avail = '1;
    #1;
    chk(iss_class[CW-1:0] == 2'd1, "R9 unsigned oldest on lane 0",
        int'(iss_class[CW-1:0]), 1);
    fu_avail = '0;
    drain('1, 4, "R9 unsigned");
  endtask

  initial begin
    m_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_cross_class();
    t_in_class();
    t_busy();
    t_full();
    t_flush();
    t_unsigned();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule